// File: doc/BRIEF.md
# Configurable SPI Master Transfer Engine

This block moves one character at a time over a four-wire serial link as the bus master. Software programs a mode byte (idle clock level, which clock edge samples, 8-bit or 16-bit character, interrupt gate) and a divider byte through a small register port. A pulse on the load input with a word on the transmit data input starts a transfer. The engine drives the serial clock, shifts the character out most significant bit first on the output line and collects the input line into a receive word.

When the last bit is in, the engine sets a sticky completion flag and updates the receive output. It also keeps sticky flags for a load while busy (collision), a completion while the previous one is still unacknowledged (overrun), and an external fault input (which also aborts the transfer). One interrupt line reports any flag when the mode byte's enable bit is set. Software clears flags by writing zeros to the status byte.

Top module: `spi_master_engine`

## Requirements
- R1: After reset the mode byte, divider byte and status byte all read 0, the serial clock is low, the output line is low and the interrupt is low.
- R2: Register addresses: 0 = mode byte (bit0 idle clock level, bit1 sample-edge select, bit2 character length, bit7 interrupt enable; bits 6:3 always read 0), 1 = divider byte, 2 = status byte (bit0 complete, bit1 overrun, bit2 collision, bit3 fault; upper bits read 0), 3 reads 0.
- R3: While idle the serial clock equals the idle-level bit. During a transfer it toggles once every (divider + 1) system clocks, giving a rate of half the system clock over (divider + 1).
- R4: The first edge after idle is the active edge. With bit1 = 0 the input line is sampled on every active edge and the output changes on every inactive edge. With bit1 = 1 the input is sampled on inactive edges and the output changes on active edges other than the first. In both cases the most significant bit is on the output line from the cycle after the load.
- R5: With bit2 = 0 a transfer moves 8 bits: it sends tx_data[7:0], the received byte appears in rx_data[7:0], and rx_data[15:8] is 0. With bit2 = 1 it moves all 16 bits.
- R6: On the cycle the last edge is produced, the complete flag sets and rx_data takes the received character.
- R7: A load while a transfer runs sets the collision flag and leaves the running transfer unchanged.
- R8: A completion while the complete flag is already set sets the overrun flag and still replaces rx_data.
- R9: Flags are sticky. A write to the status byte clears each flag whose data bit is 0 and keeps each whose bit is 1. A hardware set in the same cycle wins.
- R10: A high fault input sets the fault flag, aborts any transfer without setting the complete flag, returns the clock to idle, and prevents a load in that cycle from starting.
- R11: The interrupt output is high exactly when the enable bit is 1 and at least one status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| tx_load | input | 1 | Start pulse, accepted when idle |
| tx_data | input | 16 | Character to send |
| rx_data | output | 16 | Last received character |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fault_in | input | 1 | Mode fault input |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with its defaults, a 16-bit word and an 8-bit divider. This reaches both character lengths and every polarity and phase pairing. The divider is exercised at 0, 1 and 3, so single-cycle and multi-cycle half periods are both covered without long runs. A loopback of the output line into the input line checks that the sample and shift edges of each mode return the sent character unchanged. A behavioural model compares clock, data, receive word and interrupt every cycle while collisions, overruns, faults and flag clears are injected.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef struct packed {
        logic ien;
        logic len16;
        logic pha;
        logic pol;
    } mode_t;

    typedef struct packed {
        logic modf;
        logic wcol;
        logic ovr;
        logic done;
    } flags_t;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // R3: one tick per (ratio + 1) cycles while running
    always_comb begin
        tick  = run && (cnt_q == ratio);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              len16,
    input  logic              pha,
    input  logic              pol,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int HALF = WORD_W / 2;
    localparam int EW   = $clog2(2 * WORD_W + 1);

    typedef struct packed {
        logic              busy;
        logic              long;
        logic              pha;
        logic              sclk;
        logic [EW-1:0]     edges;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } sh_t;

    sh_t d, q;
    logic [EW-1:0] ecnt;
    logic odd, samp, shft, last;

    always_comb begin
        d    = q;
        done = 1'b0;
        ecnt = q.edges + 1'b1;
        odd  = ecnt[0];
        // R4: odd edges are active edges
        samp = q.pha ? !odd : odd;
        shft = q.pha ? (odd && (ecnt != EW'(1))) : !odd;
        last = (ecnt == (q.long ? EW'(2 * WORD_W) : EW'(WORD_W)));
        if (abort) begin
            d.busy = 1'b0;                       // R10
            d.sclk = pol;
        end else if (start) begin
            d.busy  = 1'b1;
            d.long  = len16;
            d.pha   = pha;
            d.sclk  = pol;
            d.edges = '0;
            d.rx    = '0;
            d.tx    = len16 ? tx_word : {tx_word[HALF-1:0], {HALF{1'b0}}}; // R5
        end else if (q.busy && tick) begin
            d.sclk  = !q.sclk;
            d.edges = ecnt;
            if (samp) d.rx = {q.rx[WORD_W-2:0], miso};
            if (shft) d.tx = {q.tx[WORD_W-2:0], 1'b0};
            if (last) begin
                d.busy = 1'b0;
                done   = 1'b1;                   // R6
            end
        end else if (!q.busy) begin
            d.sclk = pol;                        // R3
        end
        rx_word = q.long ? d.rx : {{HALF{1'b0}}, d.rx[HALF-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign sclk = q.sclk;
    assign mosi = q.busy & q.tx[WORD_W-1];
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
    import spi_eng_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_data,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    input  logic              fault_in,
    output logic              irq
);
    typedef struct packed {
        mode_t             cfg;
        logic [DIV_W-1:0]  div;
        flags_t            flags;
        logic [WORD_W-1:0] rx_buf;
    } top_t;

    top_t d, q;
    logic busy, tick, sh_done, start;
    logic [WORD_W-1:0] sh_rx;

    assign start = tx_load && !busy && !fault_in;   // R10 blocks start

    spi_eng_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .ratio(q.div), .tick(tick)
    );

    spi_eng_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(fault_in), .tick(tick),
        .len16(q.cfg.len16), .pha(q.cfg.pha), .pol(q.cfg.pol), .tx_word(tx_data),
        .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi), .done(sh_done),
        .rx_word(sh_rx)
    );

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (reg_addr)
                A_MODE: d.cfg = '{ien: reg_wdata[7], len16: reg_wdata[2],
                                  pha: reg_wdata[1], pol: reg_wdata[0]};   // R2
                A_DIV:  d.div = reg_wdata[DIV_W-1:0];
                A_STAT: d.flags = q.flags & reg_wdata[3:0];                 // R9
                default: ;
            endcase
        end
        if (fault_in)        d.flags.modf = 1'b1;                           // R10
        if (tx_load && busy) d.flags.wcol = 1'b1;                           // R7
        if (sh_done) begin
            if (q.flags.done) d.flags.ovr = 1'b1;                           // R8
            d.flags.done = 1'b1;
            d.rx_buf     = sh_rx;
        end
    end

    always_comb begin
        case (reg_addr)
            A_MODE:  reg_rdata = {q.cfg.ien, 4'b0000, q.cfg.len16, q.cfg.pha, q.cfg.pol};
            A_DIV:   reg_rdata = 8'(q.div);
            A_STAT:  reg_rdata = {4'b0000, q.flags};
            default: reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;                                                // R1
        else        q <= d;
    end

    assign rx_data = q.rx_buf;
    assign irq     = q.cfg.ien && (q.flags != '0);                          // R11
endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk
    import spi_eng_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   busy,
    input logic   sclk,
    input logic   tx_load,
    input logic   fault_in,
    input logic   irq,
    input mode_t  cfg,
    input flags_t flags
);
    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sclk == $past(cfg.pol)));

    p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (flags.done || $past(fault_in)));

    p_collision_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_load) |=> flags.wcol);

    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(flags.done) && !$past(fault_in)) |-> flags.ovr);

    p_fault_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> (flags.modf && !busy));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.ien |-> !irq);
endmodule

bind spi_master_engine spi_master_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(sclk), .tx_load(tx_load),
    .fault_in(fault_in), .irq(irq), .cfg(q.cfg), .flags(q.flags)
);

// File: tb/spi_master_engine_tb.sv
module spi_master_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, reg_wr = 0, tx_load = 0, miso = 0, fault_in = 0;
    logic [1:0]  reg_addr = 0;
    logic [7:0]  reg_wdata = 0, reg_rdata;
    logic [15:0] tx_data = 0, rx_data;
    logic sclk, mosi, irq;

    int n_chk = 0, n_fail = 0;
    bit chk_on = 0, loop = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    int m_pol = 0, m_pha = 0, m_len = 0, m_ien = 0, m_div = 0;
    int m_done = 0, m_ovr = 0, m_wcol = 0, m_modf = 0;
    int m_busy = 0, m_cnt = 0, m_edge = 0, m_sclk = 0, m_tx = 0, m_rx = 0, m_rxbuf = 0;
    int m_lng = 0, m_mpha = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_master_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_load(tx_load),
        .tx_data(tx_data), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .fault_in(fault_in), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int tk, ob, od, e, odd, samp, shf, fin;
        if (!rst_n) begin
            m_pol = 0; m_pha = 0; m_len = 0; m_ien = 0; m_div = 0;
            m_done = 0; m_ovr = 0; m_wcol = 0; m_modf = 0;
            m_busy = 0; m_cnt = 0; m_edge = 0; m_sclk = 0; m_tx = 0; m_rx = 0; m_rxbuf = 0;
        end else begin
            ob = m_busy; od = m_done; fin = 0;
            tk = (m_busy != 0) && (m_cnt == m_div);
            m_cnt = (ob == 0) ? 0 : ((m_cnt == m_div) ? 0 : m_cnt + 1);
            if (fault_in) begin
                m_busy = 0; m_sclk = m_pol;
            end else if (tx_load && ob == 0) begin
                m_busy = 1; m_lng = m_len; m_mpha = m_pha; m_sclk = m_pol;
                m_edge = 0; m_rx = 0;
                m_tx = m_len ? int'(tx_data) : ((int'(tx_data) & 'hFF) << 8);
            end else if (ob != 0 && tk != 0) begin
                e = m_edge + 1; m_edge = e; m_sclk = !m_sclk;
                odd = e % 2;
                samp = m_mpha ? !odd : odd;
                shf  = m_mpha ? (odd && e != 1) : !odd;
                if (samp) m_rx = ((m_rx << 1) | miso) & 'hFFFF;
                if (shf)  m_tx = (m_tx << 1) & 'hFFFF;
                if (e == (m_lng ? 32 : 16)) begin m_busy = 0; fin = 1; end
            end else if (ob == 0) begin
                m_sclk = m_pol;
            end
            if (reg_wr && reg_addr == 2) begin
                m_done &= reg_wdata[0]; m_ovr &= reg_wdata[1];
                m_wcol &= reg_wdata[2]; m_modf &= reg_wdata[3];
            end
            if (fault_in) m_modf = 1;
            if (tx_load && ob != 0) m_wcol = 1;
            if (fin) begin
                if (od) m_ovr = 1;
                m_done = 1;
                m_rxbuf = m_lng ? m_rx : (m_rx & 'hFF);
            end
            if (reg_wr && reg_addr == 0) begin
                m_pol = reg_wdata[0]; m_pha = reg_wdata[1];
                m_len = reg_wdata[2]; m_ien = reg_wdata[7];
            end
            if (reg_wr && reg_addr == 1) m_div = reg_wdata;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            check("R3 sclk", sclk, m_sclk);
            check("R4 mosi", mosi, m_busy ? ((m_tx >> 15) & 1) : 0);
            check("R6 rx_data", rx_data, m_rxbuf);
            check("R11 irq", irq, m_ien && (m_done || m_ovr || m_wcol || m_modf));
        end
    end

    // input line source: loopback or pseudo-random bits
    always @(negedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = loop ? mosi : lfsr[0];
    end

    task automatic cyc();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v; cyc(); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        reg_addr = a; #1; check(tag, reg_rdata, exp);
    endtask

    task automatic load(input logic [15:0] v);
        tx_load = 1; tx_data = v; cyc(); tx_load = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && m_busy != 0; i++) cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1; chk_on = 1;
        cyc();
        // R1 reset state
        rd(0, 0, "R1 mode"); rd(1, 0, "R1 div"); rd(2, 0, "R1 status");
        check("R1 sclk", sclk, 0); check("R1 mosi", mosi, 0); check("R1 irq", irq, 0);
        // R2 register layout
        wr(0, 8'hFF); rd(0, 8'h87, "R2 reserved bits");
        rd(3, 0, "R2 unused address");
        wr(1, 8'h5A); rd(1, 8'h5A, "R2 div readback");
        wr(0, 8'h00); cyc();
        check("R3 idle low", sclk, 0);

        // R4 R5 loopback in every mode and length
        loop = 1;
        for (int md = 0; md < 4; md++) begin
            for (int ln = 0; ln < 2; ln++) begin
                logic [15:0] w;
                w = 16'hB3C5 ^ 16'(md * 16'h1111 + ln * 16'h0F0F);
                wr(1, 8'((md + ln) % 3 == 2 ? 3 : (md + ln) % 3));
                wr(0, 8'(md | (ln << 2)));
                cyc();
                check("R3 idle level", sclk, md & 1);
                load(w);
                wait_idle(); cyc();
                check("R5 loopback word", rx_data, ln ? w : {8'h00, w[7:0]});
                rd(2, 1, "R6 complete flag");
                wr(2, 8'h00); rd(2, 0, "R9 clear all");
            end
        end
        loop = 0;

        // R7 collision: load while busy
        wr(0, 8'h04); wr(1, 8'h01);
        load(16'h1234); cyc(); load(16'hFFFF);
        rd(2, 4, "R7 collision flag");
        wait_idle(); cyc();
        rd(2, 5, "R7 transfer finished");

        // R8 overrun: second completion with complete flag set
        wr(0, 8'h00); wr(1, 8'h00);
        load(16'h00A5); wait_idle(); cyc();
        rd(2, 8'h07, "R8 overrun flag");

        // R9 selective clear keeps bits written 1
        wr(2, 8'hFD); rd(2, 8'h05, "R9 keep others");
        wr(2, 8'hFA); rd(2, 8'h00, "R9 clear rest");

        // R10 fault aborts
        wr(1, 8'h02); wr(0, 8'h01);
        load(16'h00C3);
        repeat (7) cyc();
        fault_in = 1; cyc(); fault_in = 0; cyc();
        rd(2, 8'h08, "R10 fault only");
        check("R10 clock idle", sclk, 1);
        fault_in = 1; tx_load = 1; tx_data = 16'h0077; cyc(); tx_load = 0; fault_in = 0;
        repeat (3) cyc();
        check("R10 load blocked", sclk, 1);

        // R11 interrupt gating
        check("R11 disabled", irq, 0);
        wr(0, 8'h81); cyc();
        check("R11 enabled", irq, 1);
        wr(2, 8'h00); cyc();
        check("R11 no flags", irq, 0);

        // random-input transfers under the cycle model
        for (int k = 0; k < 6; k++) begin
            wr(0, 8'(8'h80 | (k % 8)));
            wr(1, 8'(k % 3));
            load(16'(16'h9E37 * (k + 1)));
            wait_idle(); cyc();
            wr(2, 8'h00);
        end
        repeat (4) cyc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule